// File: doc/BRIEF.md
# Bus Fault Classification Controller

This block sits between the sequencer of a small pipelined core and its bus interface. It watches every bus cycle the core completes. When a cycle ends with a bus error, the block sorts the fault into one of four categories and decides when the exception is taken. It also assembles a 16-bit special status word and a record that the exception sequencer then stacks: program counter, status register, faulted address and data.

A fault on a released write is not taken at once. A released write is a final write that the next instruction is allowed to overlap. Its fault is latched and reported at the next instruction boundary. It is reported earlier if a following instruction requests an operand, and that instruction is then aborted so it cannot consume stale data. Every other faulted cycle is reported immediately and raises a one-cycle restore request. That request lets the address-register rollback logic undo postincrement and predecrement side effects before the instruction restarts. A second fault that arrives while a released-write fault is pending is queued and reported after the pending one.

Top module: `bus_fault_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `exc_req`, `restore_req` and `abort_insn` are low.
- R2: The cycle kind is encoded 0 fetch, 1 operand read, 2 read-modify-write, 3 peripheral move, 4 multi-register move transfer, 5 exception-stacking cycle and 6 released write. The category on `exc_cat` is 0 for a released write, 1 for exception processing, 2 for a multi-register move and 3 for all other kinds.
- R3: A released-write fault raises no request while it waits. An `insn_boundary` strobe seen in a later cycle launches it, and `exc_req` is high after the next edge.
- R4: An `operand_req` strobe seen while a released-write fault is pending launches that fault at the next edge. In the same cycle, `abort_insn` pulses high for exactly one cycle.
- R5: A fault of any other kind raises `exc_req` after the second clock edge following the faulted cycle. `restore_req` pulses high for that first cycle only.
- R6: The status word layout is: bits 15:14 zero, 13 trace pending, 12 breakpoint 1, 11 breakpoint 0, 10 released-write flag, 9 read-modify-write, 8 instruction fetch, 7 read (1) or write (0), 6 size-count bit, 5:4 transfer size, 3 zero, 2:0 function code.
- R7: The breakpoint bits and, for a released write, the trace bit copy the pending inputs at the launch edge. For every other category the trace bit is 0.
- R8: `rec_pc` and `rec_sr` capture `pc_in` and `sr_in` at the launch edge. `rec_addr` and `rec_data` hold the faulted cycle's address and data.
- R9: `exc_req` and its record stay constant until `exc_ack` is seen, and drop at that edge.
- R10: A fault arriving while a released-write fault is pending forces the pending one out first. The new one is reported after the acknowledge.
- R11: A cycle without `bus_err`, or `bus_err` without `cyc_valid`, raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A bus cycle completes this cycle |
| cyc_kind | input | 3 | Cycle kind code (R2) |
| cyc_read | input | 1 | 1 for a read cycle |
| cyc_szc | input | 1 | Size-count bit of the cycle |
| cyc_size | input | 2 | Transfer size |
| cyc_fc | input | 3 | Function code |
| cyc_addr | input | AW | Cycle address |
| cyc_data | input | DW | Cycle data buffer |
| bus_err | input | 1 | Cycle ended in a bus error |
| insn_boundary | input | 1 | Instruction boundary strobe |
| operand_req | input | 1 | Following instruction requests an operand |
| pc_in | input | PCW | Program counter offered for stacking |
| sr_in | input | SRW | Current status register |
| trace_pend | input | 1 | Trace exception pending |
| bkpt1_pend | input | 1 | Breakpoint 1 pending |
| bkpt0_pend | input | 1 | Breakpoint 0 pending |
| exc_ack | input | 1 | Sequencer accepts the report |
| exc_req | output | 1 | Exception report valid |
| exc_cat | output | 2 | Fault category |
| ssw | output | 16 | Special status word |
| rec_pc | output | PCW | Stacked program counter |
| rec_sr | output | SRW | Stacked status register |
| rec_addr | output | AW | Faulted address |
| rec_data | output | DW | Faulted data buffer |
| restore_req | output | 1 | Register rollback request |
| abort_insn | output | 1 | Abort the instruction requesting an operand |

## Verification
Two things can land on the same edge: the launch of a pending released-write fault and the capture of a newly faulted cycle. Both also compete with the operand-request abort. The bench provokes the first collision by faulting an instruction fetch in the cycle right after a released-write fault is latched. It then expects a category-0 report without a restore request, and after the acknowledge a category-3 report with one. In the operand collision, the bench requires `abort_insn` and `exc_req` to appear after the same edge and the abort to vanish one cycle later.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [2:0] {
        K_FETCH  = 3'd0,
        K_OPRD   = 3'd1,
        K_RMW    = 3'd2,
        K_PERIPH = 3'd3,
        K_MULTI  = 3'd4,
        K_EXCSTK = 3'd5,
        K_RELWR  = 3'd6,
        K_SPARE  = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        CAT_REL   = 2'd0,
        CAT_EXC   = 2'd1,
        CAT_MULTI = 2'd2,
        CAT_OTHER = 2'd3
    } fault_cat_e;

    typedef struct packed {
        cyc_kind_e  kind;
        logic       rd;
        logic       szc;
        logic [1:0] siz;
        logic [2:0] fc;
    } cyc_meta_t;

    localparam int SSW_W = 16;

    function automatic fault_cat_e cat_of(cyc_kind_e k);
        case (k)
            K_RELWR:  return CAT_REL;
            K_EXCSTK: return CAT_EXC;
            K_MULTI:  return CAT_MULTI;
            default:  return CAT_OTHER;
        endcase
    endfunction

    function automatic logic [SSW_W-1:0] build_ssw(cyc_meta_t m, logic tr,
                                                   logic b1, logic b0);
        logic rel, rmw, ifetch;
        rel    = (m.kind == K_RELWR);
        rmw    = (m.kind == K_RMW);
        ifetch = (m.kind == K_FETCH);
        return {2'b00, tr, b1, b0, rel, rmw, ifetch, m.rd, m.szc, m.siz,
                1'b0, m.fc};
    endfunction

endpackage

// File: rtl/bfc_classify.sv
module bfc_classify
    import bfc_pkg::*;
(
    input  logic       cyc_valid,
    input  logic       bus_err,
    input  cyc_kind_e  kind,
    output logic       fault_now,
    output logic       deferred,
    output fault_cat_e cat
);
    always_comb begin
        fault_now = cyc_valid && bus_err;
        cat       = cat_of(kind);
        deferred  = (cat == CAT_REL);
    end
endmodule

// File: rtl/bfc_slot.sv
module bfc_slot
    import bfc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clr,
    input  cyc_meta_t     meta_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          valid,
    output cyc_meta_t     meta,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            meta  <= '0;
            addr  <= '0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            meta  <= meta_in;
            addr  <= addr_in;
            data  <= data_in;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end

    // R10: a held record is never overwritten before it is reported
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        valid && !clr |-> !load);
endmodule

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
    import bfc_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int PCW = 32,
    parameter int SRW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_valid,
    input  logic [2:0]       cyc_kind,
    input  logic             cyc_read,
    input  logic             cyc_szc,
    input  logic [1:0]       cyc_size,
    input  logic [2:0]       cyc_fc,
    input  logic [AW-1:0]    cyc_addr,
    input  logic [DW-1:0]    cyc_data,
    input  logic             bus_err,
    input  logic             insn_boundary,
    input  logic             operand_req,
    input  logic [PCW-1:0]   pc_in,
    input  logic [SRW-1:0]   sr_in,
    input  logic             trace_pend,
    input  logic             bkpt1_pend,
    input  logic             bkpt0_pend,
    input  logic             exc_ack,
    output logic             exc_req,
    output logic [1:0]       exc_cat,
    output logic [SSW_W-1:0] ssw,
    output logic [PCW-1:0]   rec_pc,
    output logic [SRW-1:0]   rec_sr,
    output logic [AW-1:0]    rec_addr,
    output logic [DW-1:0]    rec_data,
    output logic             restore_req,
    output logic             abort_insn
);
    localparam int NSLOT = 2;
    localparam int PEND  = 0;
    localparam int READY = 1;

    cyc_meta_t  in_meta;
    logic       fault_now, deferred;
    fault_cat_e in_cat;

    logic [NSLOT-1:0] s_load, s_clr, s_valid;
    cyc_meta_t        s_meta [NSLOT];
    logic [AW-1:0]    s_addr [NSLOT];
    logic [DW-1:0]    s_data [NSLOT];

    logic       pend_fire;
    logic       launch_pend, launch_ready;
    fault_cat_e ready_cat;

    always_comb begin
        in_meta.kind = cyc_kind_e'(cyc_kind);
        in_meta.rd   = cyc_read;
        in_meta.szc  = cyc_szc;
        in_meta.siz  = cyc_size;
        in_meta.fc   = cyc_fc;
    end

    bfc_classify u_cls (
        .cyc_valid (cyc_valid),
        .bus_err   (bus_err),
        .kind      (in_meta.kind),
        .fault_now (fault_now),
        .deferred  (deferred),
        .cat       (in_cat)
    );

    always_comb begin
        ready_cat    = cat_of(s_meta[READY].kind);
        launch_pend  = !exc_req && s_valid[PEND] &&
                       (pend_fire || insn_boundary || operand_req || s_valid[READY]);
        launch_ready = !exc_req && s_valid[READY] && !launch_pend;
        s_clr[PEND]  = launch_pend;
        s_clr[READY] = launch_ready;
        s_load[PEND] = fault_now && deferred && (!s_valid[PEND] || launch_pend);
        s_load[READY] = fault_now && !s_load[PEND] &&
                        (!s_valid[READY] || launch_ready);
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        bfc_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .load    (s_load[g]),
            .clr     (s_clr[g]),
            .meta_in (in_meta),
            .addr_in (cyc_addr),
            .data_in (cyc_data),
            .valid   (s_valid[g]),
            .meta    (s_meta[g]),
            .addr    (s_addr[g]),
            .data    (s_data[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_req     <= 1'b0;
            exc_cat     <= CAT_OTHER;
            ssw         <= '0;
            rec_pc      <= '0;
            rec_sr      <= '0;
            rec_addr    <= '0;
            rec_data    <= '0;
            restore_req <= 1'b0;
            abort_insn  <= 1'b0;
            pend_fire   <= 1'b0;
        end else begin
            restore_req <= 1'b0;
            abort_insn  <= s_valid[PEND] && operand_req;
            if (exc_req && exc_ack)
                exc_req <= 1'b0;
            if (launch_pend) begin
                exc_req   <= 1'b1;
                exc_cat   <= CAT_REL;
                ssw       <= build_ssw(s_meta[PEND], trace_pend, bkpt1_pend, bkpt0_pend);
                rec_pc    <= pc_in;
                rec_sr    <= sr_in;
                rec_addr  <= s_addr[PEND];
                rec_data  <= s_data[PEND];
                pend_fire <= 1'b0;
            end else if (launch_ready) begin
                exc_req     <= 1'b1;
                exc_cat     <= ready_cat;
                ssw         <= build_ssw(s_meta[READY],
                                         (ready_cat == CAT_REL) && trace_pend,
                                         bkpt1_pend, bkpt0_pend);
                rec_pc      <= pc_in;
                rec_sr      <= sr_in;
                rec_addr    <= s_addr[READY];
                rec_data    <= s_data[READY];
                restore_req <= (ready_cat != CAT_REL);
            end else if (s_valid[PEND] && (insn_boundary || operand_req)) begin
                pend_fire <= 1'b1;
            end
        end
    end

    // R9: report stays put until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        exc_req && !exc_ack |=> exc_req && $stable(ssw) && $stable(exc_cat));
    // R9: acknowledge drops the request
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        exc_req && exc_ack |=> !exc_req);
    // R5: rollback request only on the first cycle of a non-deferred report
    a_r5_restore_first: assert property (@(posedge clk) disable iff (rst)
        restore_req |-> $rose(exc_req) && (exc_cat != CAT_REL));
    // R7: trace bit cleared on restartable faults
    a_r7_tr_clear: assert property (@(posedge clk) disable iff (rst)
        exc_req && (exc_cat != CAT_REL) |-> !ssw[13]);
    // R6: released-write flag agrees with category
    a_r6_rel_flag: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (ssw[10] == (exc_cat == CAT_REL)));
    // R4: abort only follows an operand request
    a_r4_abort_cause: assert property (@(posedge clk) disable iff (rst)
        abort_insn |-> $past(operand_req));
    // R4: abort is a single-cycle pulse
    a_r4_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        abort_insn |=> !abort_insn || $past(operand_req));
endmodule

// File: tb/bus_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_fault_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_valid, cyc_read, cyc_szc, bus_err;
    logic [2:0]  cyc_kind, cyc_fc;
    logic [1:0]  cyc_size;
    logic [31:0] cyc_addr, cyc_data, pc_in;
    logic [15:0] sr_in;
    logic        insn_boundary, operand_req, trace_pend, bkpt1_pend, bkpt0_pend, exc_ack;
    logic        exc_req, restore_req, abort_insn;
    logic [1:0]  exc_cat;
    logic [15:0] ssw, rec_sr;
    logic [31:0] rec_pc, rec_addr, rec_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_fault_ctrl dut_i (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .cyc_read(cyc_read), .cyc_szc(cyc_szc), .cyc_size(cyc_size), .cyc_fc(cyc_fc),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data), .bus_err(bus_err),
        .insn_boundary(insn_boundary), .operand_req(operand_req), .pc_in(pc_in),
        .sr_in(sr_in), .trace_pend(trace_pend), .bkpt1_pend(bkpt1_pend),
        .bkpt0_pend(bkpt0_pend), .exc_ack(exc_ack), .exc_req(exc_req),
        .exc_cat(exc_cat), .ssw(ssw), .rec_pc(rec_pc), .rec_sr(rec_sr),
        .rec_addr(rec_addr), .rec_data(rec_data), .restore_req(restore_req),
        .abort_insn(abort_insn)
    );

    // {kind[27:25], rd[24], szc[23], siz[22:21], fc[20:18], cat[17:16], ssw[15:0]}
    // driven with trace_pend=1, bkpt1=0, bkpt0=1
    localparam logic [27:0] VEC [6] = '{
        {3'd0, 1'b1, 1'b0, 2'b10, 3'd6, 2'd3, 16'h09A6},
        {3'd1, 1'b1, 1'b1, 2'b01, 3'd5, 2'd3, 16'h08D5},
        {3'd2, 1'b0, 1'b0, 2'b00, 3'd1, 2'd3, 16'h0A01},
        {3'd3, 1'b0, 1'b1, 2'b01, 3'd2, 2'd3, 16'h0852},
        {3'd4, 1'b1, 1'b0, 2'b10, 3'd5, 2'd2, 16'h08A5},
        {3'd5, 1'b0, 1'b1, 2'b11, 3'd7, 2'd1, 16'h0877}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cyc_valid = 0; bus_err = 0; insn_boundary = 0; operand_req = 0; exc_ack = 0;
    endtask

    // drive a faulted cycle for one clock; returns just after the capturing edge
    task automatic fault(logic [2:0] k, logic rd, logic szc, logic [1:0] siz,
                         logic [2:0] fc, logic [31:0] a, logic [31:0] d, logic err);
        @(negedge clk);
        cyc_valid = 1; bus_err = err; cyc_kind = k; cyc_read = rd; cyc_szc = szc;
        cyc_size = siz; cyc_fc = fc; cyc_addr = a; cyc_data = d;
        @(posedge clk); #1;
        cyc_valid = 0; bus_err = 0;
    endtask

    task automatic ack(string tag);
        @(negedge clk); exc_ack = 1;
        @(posedge clk); #1; exc_ack = 0;
        chk(tag, {31'd0, exc_req}, 32'd0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        idle_inputs();
        cyc_kind = 0; cyc_read = 0; cyc_szc = 0; cyc_size = 0; cyc_fc = 0;
        cyc_addr = 0; cyc_data = 0; pc_in = 32'h100; sr_in = 16'h2700;
        trace_pend = 0; bkpt1_pend = 0; bkpt0_pend = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        chk("R1 exc_req", {31'd0, exc_req}, 0);
        chk("R1 restore", {31'd0, restore_req}, 0);
        chk("R1 abort", {31'd0, abort_insn}, 0);

        // R2 R5 R6 R7: table of immediate faults
        trace_pend = 1; bkpt1_pend = 0; bkpt0_pend = 1;
        foreach (VEC[i]) begin
            logic [27:0] v;
            v = VEC[i];
            fault(v[27:25], v[24], v[23], v[22:21], v[20:18], 32'hA000 + i, 32'hD000 + i, 1);
            chk("R5 no early req", {31'd0, exc_req}, 0);
            @(posedge clk); #1;
            chk("R5 req", {31'd0, exc_req}, 1);
            chk("R5 restore", {31'd0, restore_req}, 1);
            chk("R2 category", {30'd0, exc_cat}, {30'd0, v[17:16]});
            chk("R6 R7 ssw", {16'd0, ssw}, {16'd0, v[15:0]});
            chk("R8 addr", rec_addr, 32'hA000 + i);
            @(posedge clk); #1;
            chk("R5 restore pulse", {31'd0, restore_req}, 0);
            ack("R9 ack drop");
        end
        trace_pend = 0; bkpt0_pend = 0;

        // R11: partial strobes raise nothing
        fault(3'd0, 1, 0, 2'b10, 3'd6, 32'h1, 32'h2, 0);
        @(negedge clk); bus_err = 1;
        @(posedge clk); #1; bus_err = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R11 no req", {31'd0, exc_req}, 0);
        chk("R11 no restore", {31'd0, restore_req}, 0);

        // R3 R7 R8: released write waits for boundary
        fault(3'd6, 0, 1, 2'b11, 3'd1, 32'h4444, 32'hCAFE, 1);
        repeat (3) @(posedge clk);
        #1;
        chk("R3 deferred", {31'd0, exc_req}, 0);
        @(negedge clk);
        insn_boundary = 1; pc_in = 32'h2040; sr_in = 16'h0014;
        trace_pend = 1; bkpt1_pend = 1; bkpt0_pend = 0;
        @(posedge clk); #1; insn_boundary = 0;
        chk("R3 taken", {31'd0, exc_req}, 1);
        chk("R2 released cat", {30'd0, exc_cat}, 0);
        chk("R6 R7 released ssw", {16'd0, ssw}, 32'h3471);
        chk("R3 no restore", {31'd0, restore_req}, 0);
        chk("R8 pc", rec_pc, 32'h2040);
        chk("R8 sr", {16'd0, rec_sr}, 32'h0014);
        chk("R8 data", rec_data, 32'hCAFE);
        chk("R8 addr", rec_addr, 32'h4444);
        // R9: held without acknowledge
        held = ssw;
        repeat (4) @(posedge clk);
        #1;
        chk("R9 held req", {31'd0, exc_req}, 1);
        chk("R9 held ssw", {16'd0, ssw}, {16'd0, held});
        ack("R9 ack");
        trace_pend = 0; bkpt1_pend = 0;

        // R4: operand request aborts and takes the pending fault
        fault(3'd6, 0, 0, 2'b01, 3'd5, 32'h88, 32'h99, 1);
        @(posedge clk); #1;
        chk("R4 waiting", {31'd0, exc_req}, 0);
        @(negedge clk); operand_req = 1;
        @(posedge clk); #1; operand_req = 0;
        chk("R4 abort", {31'd0, abort_insn}, 1);
        chk("R4 req", {31'd0, exc_req}, 1);
        chk("R4 cat", {30'd0, exc_cat}, 0);
        @(posedge clk); #1;
        chk("R4 abort pulse", {31'd0, abort_insn}, 0);
        ack("R4 ack");

        // R10: immediate fault behind a pending released write
        fault(3'd6, 0, 0, 2'b10, 3'd1, 32'h300, 32'h301, 1);
        fault(3'd0, 1, 0, 2'b10, 3'd6, 32'h500, 32'h501, 1);
        @(posedge clk); #1;
        chk("R10 first req", {31'd0, exc_req}, 1);
        chk("R10 first cat", {30'd0, exc_cat}, 0);
        chk("R10 first addr", rec_addr, 32'h300);
        chk("R10 first no restore", {31'd0, restore_req}, 0);
        ack("R10 ack");
        @(posedge clk); #1;
        chk("R10 second req", {31'd0, exc_req}, 1);
        chk("R10 second cat", {30'd0, exc_cat}, 3);
        chk("R10 second addr", rec_addr, 32'h500);
        chk("R10 second restore", {31'd0, restore_req}, 1);
        ack("R10 ack2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule